// File: doc/BRIEF.md
# I2C Target Bridge to a 32-bit Register Port

This block lets an external I2C controller read and write a bank of 32-bit registers. SCL and SDA are sampled with the system clock, passed through a two-flop synchronizer and a glitch filter, and decoded into SCL edges and bus start and stop events. A state machine recognises the 7-bit target address, takes in an 8-bit register index, and moves 32-bit words across a simple parallel register port. Each word travels as four bytes, most significant byte and bit first. The target drives SDA only through an active-low output enable. It never drives the line high.

A write header (address with R/W = 0, then an index byte) loads an internal word pointer. Data bytes that follow are packed into words. Each complete word produces a one-cycle write strobe and advances the pointer by four. A read (R/W = 1) fetches the word at the pointer with a one-cycle read strobe, latches it and shifts it out. Each read continues word after word for as long as the controller acknowledges. A header that ends at a stop or repeated start only sets the pointer, which a later read then uses.

State machine. The states are IDLE, CTRL (receive the address byte), CTRL_ACK, ADDR (receive the index), ADDR_ACK, WDATA, WDATA_ACK, WSTROBE, RLOAD, RDATA, RACK (sample the controller's acknowledge) and IGNORE. The transitions are as follows:
- A start from any state goes to CTRL. A stop from any state goes to IDLE.
- CTRL goes to CTRL_ACK on an address match and to IGNORE on a mismatch.
- CTRL_ACK goes to RLOAD if R/W = 1, or to ADDR if R/W = 0.
- ADDR goes to ADDR_ACK, and ADDR_ACK goes to WDATA.
- WDATA goes to WDATA_ACK. WDATA_ACK goes to WSTROBE after the fourth byte of a word, or back to WDATA otherwise. WSTROBE goes to WDATA.
- RLOAD goes to RDATA, and RDATA goes to RACK after eight bits.
- RACK goes to RLOAD after an acknowledged fourth byte, or to RDATA after an acknowledged earlier byte. A not-acknowledge goes to IGNORE.
- IGNORE leaves only on a start.

Top module: `i2c_reg_bridge`

## Requirements
- R1: A control byte whose upper seven bits equal 0001010 (first bit on the wire is the most significant) is acknowledged: the target pulls SDA low during the ninth SCL pulse. Bit 0 of the byte is R/W.
- R2: A control byte with any other address is not acknowledged. Until the next start, the target drives SDA for no bit of any later byte and issues no strobe.
- R3: With R/W = 0, the next byte is acknowledged and loaded into the pointer as address bits 9..2, with bits 1..0 equal to 00. A stop or repeated start right after it causes no write but keeps the pointer.
- R4: Four data bytes, most significant byte first, form one word. `reg_wr` pulses for exactly one cycle after the fourth byte's acknowledge, with `reg_addr` equal to the pointer and `reg_wdata` equal to the word. `reg_wr` and `reg_rd` are never high together.
- R5: The pointer rises by 4 after each written word, wrapping within 10 bits (0x3FC is followed by 0x000).
- R6: A word cut short by a stop or a start is not written, and the pointer does not advance.
- R7: With R/W = 1, `reg_rd` pulses for one cycle at the start of each word. `reg_rdata` is captured in that cycle and its four bytes are sent most significant first. Later changes of `reg_rdata` do not alter the bytes sent.
- R8: In a read, a controller acknowledge after a word's fourth byte continues with the next word. The pointer rises by 4 after every fourth byte sent, whether it is acknowledged or not. A read stopped after fewer than four bytes leaves the pointer unchanged.
- R9: A not-acknowledge from the controller ends the read. SDA stays released, even while SCL keeps toggling, until the next start.
- R10: Pulses of fewer than FILT_LEN system clocks (default 4) on SDA or SCL are filtered out and create no false start, stop or bit.
- R11: The target changes its SDA drive only while SCL is low. It can only pull SDA low (`sda_oe` = 1) or release it.
- R12: After reset, `sda_oe`, `reg_wr` and `reg_rd` are 0 and the pointer (`reg_addr`) is 0.
- R13: Transfers work at 400 kHz SCL and slower with a 200 MHz system clock, and at any SCL phase of at least about 20 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | 10 | Word-aligned byte address (pointer) |
| reg_wdata | output | 32 | Word to be written |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 32 | Register value, sampled in the reg_rd cycle |

## Verification
The hardest state to reach from the ports is a read that wraps the pointer from 0x3FC to 0x000, followed by a not-acknowledge while the controller keeps clocking. The stimulus reaches it with an address-only write header of 0xFF and a repeated start into a two-word read. The controller then clocks a further byte with SDA released. A second hard case is latch timing: the bench register model replaces its value right after the read strobe, so the bytes on the wire reveal whether the capture happened in the strobe cycle. An SDA glitch shorter than the filter, placed while SCL is high, shows whether a false stop or start is rejected.

// File: rtl/i2c_reg_bridge_pkg.sv
package i2c_reg_bridge_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_WSTROBE,
        ST_RLOAD,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } bridge_state_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int FILT_LEN = 4,
    localparam int CNT_W = $clog2(FILT_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] cnt_q;

    // Two-flop synchronizer, then accept a new level only after it has
    // been stable for FILT_LEN consecutive cycles.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            if (sync_q[1] != line_o) begin
                if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
                    line_o <= sync_q[1];
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
        start_evt = scl_f & scl_q & sda_q & ~sda_f;
        stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
    end

endmodule

// File: rtl/i2c_reg_bridge.sv
module i2c_reg_bridge
    import i2c_reg_bridge_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b0001010,
    parameter int FILT_LEN = 4,
    parameter int DATA_W = 32,
    localparam int BYTES  = DATA_W / 8,
    localparam int LSB_W  = $clog2(BYTES),
    localparam int ADDR_W = 8 + LSB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata
);

    localparam int IDX_W = (LSB_W > 0) ? LSB_W : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTES - 1);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BYTES);

    // ---------------- line conditioning ----------------
    logic [1:0] raw_lines;
    logic [1:0] flt_lines;
    logic       scl_f;
    logic       sda_f;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (flt_lines[g])
        );
    end

    assign scl_f = flt_lines[0];
    assign sda_f = flt_lines[1];

    logic scl_rise;
    logic scl_fall;
    logic start_evt;
    logic stop_evt;

    i2c_bus_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (scl_f),
        .sda_f     (sda_f),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    // ---------------- state and datapath ----------------
    bridge_state_e      state_q;
    bridge_state_e      state_d;
    logic [2:0]         bit_cnt_q;
    logic               byte_full_q;
    logic [BYTE_W-1:0]  rx_sr_q;
    logic [DATA_W-1:0]  tx_sr_q;
    logic [DATA_W-1:0]  wbuf_q;
    logic [ADDR_W-1:0]  ptr_q;
    logic [IDX_W-1:0]   byte_idx_q;
    logic               rw_q;
    logic               mack_q;
    logic               last_byte;
    logic               addr_hit;

    assign last_byte = (byte_idx_q == LAST_IDX);
    assign addr_hit  = (rx_sr_q[7:1] == DEV_ADDR);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start_evt) begin
            state_d = ST_CTRL;
        end else if (stop_evt) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: state_d = state_q;
                ST_CTRL: begin
                    if (scl_fall && byte_full_q) begin
                        state_d = addr_hit ? ST_CTRL_ACK : ST_IGNORE;
                    end
                end
                ST_CTRL_ACK: begin
                    if (scl_fall) begin
                        state_d = rw_q ? ST_RLOAD : ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (scl_fall && byte_full_q) state_d = ST_ADDR_ACK;
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) state_d = ST_WDATA;
                end
                ST_WDATA: begin
                    if (scl_fall && byte_full_q) state_d = ST_WDATA_ACK;
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) state_d = last_byte ? ST_WSTROBE : ST_WDATA;
                end
                ST_WSTROBE: state_d = ST_WDATA;
                ST_RLOAD:   state_d = ST_RDATA;
                ST_RDATA: begin
                    if (scl_fall && (bit_cnt_q == 3'd7)) state_d = ST_RACK;
                end
                ST_RACK: begin
                    if (scl_fall) begin
                        if (!mack_q)        state_d = ST_IGNORE;
                        else if (last_byte) state_d = ST_RLOAD;
                        else                state_d = ST_RDATA;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q   <= '0;
            byte_full_q <= 1'b0;
            rx_sr_q     <= '0;
            tx_sr_q     <= '0;
            wbuf_q      <= '0;
            ptr_q       <= '0;
            byte_idx_q  <= '0;
            rw_q        <= 1'b0;
            mack_q      <= 1'b0;
        end else if (start_evt) begin
            bit_cnt_q   <= '0;
            byte_full_q <= 1'b0;
            byte_idx_q  <= '0;
        end else begin
            unique case (state_q)
                ST_CTRL, ST_ADDR, ST_WDATA: begin
                    if (scl_rise && !byte_full_q) begin
                        rx_sr_q   <= {rx_sr_q[BYTE_W-2:0], sda_f};
                        bit_cnt_q <= bit_cnt_q + 3'd1;
                        if (bit_cnt_q == 3'd7) byte_full_q <= 1'b1;
                    end else if (scl_fall && byte_full_q) begin
                        byte_full_q <= 1'b0;
                        bit_cnt_q   <= '0;
                        if (state_q == ST_CTRL) rw_q <= rx_sr_q[0];
                        if (state_q == ST_ADDR) ptr_q <= {rx_sr_q, {LSB_W{1'b0}}};
                        if (state_q == ST_WDATA) begin
                            wbuf_q <= {wbuf_q[DATA_W-BYTE_W-1:0], rx_sr_q};
                        end
                    end
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        byte_idx_q <= last_byte ? '0 : byte_idx_q + 1'b1;
                    end
                end
                ST_WSTROBE: ptr_q <= ptr_q + STEP;
                ST_RLOAD: begin
                    tx_sr_q   <= reg_rdata;
                    bit_cnt_q <= '0;
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        tx_sr_q   <= {tx_sr_q[DATA_W-2:0], 1'b0};
                        bit_cnt_q <= bit_cnt_q + 3'd1;
                    end
                end
                ST_RACK: begin
                    if (scl_rise) mack_q <= ~sda_f;
                    if (scl_fall) begin
                        bit_cnt_q <= '0;
                        if (last_byte) begin
                            byte_idx_q <= '0;
                            ptr_q      <= ptr_q + STEP;
                        end else begin
                            byte_idx_q <= byte_idx_q + 1'b1;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe    = 1'b0;
        reg_wr    = 1'b0;
        reg_rd    = 1'b0;
        reg_addr  = ptr_q;
        reg_wdata = wbuf_q;
        unique case (state_q)
            ST_CTRL_ACK, ST_ADDR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:   sda_oe = ~tx_sr_q[DATA_W-1];
            ST_WSTROBE: reg_wr = 1'b1;
            ST_RLOAD:   reg_rd = 1'b1;
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/i2c_reg_bridge_chk.sv
module i2c_reg_bridge_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_f,
    input logic              start_evt,
    input logic              sda_oe,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr
);

    p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_f);

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    p_wr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_addr == $past(reg_addr) + ADDR_W'(4)));

    p_rd_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    p_addr_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr[1:0] == 2'b00);

    p_start_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !sda_oe);

    p_reset_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!sda_oe && !reg_wr && !reg_rd));

endmodule

bind i2c_reg_bridge i2c_reg_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (scl_f),
    .start_evt (start_evt),
    .sda_oe    (sda_oe),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr)
);

// File: tb/i2c_reg_bridge_bench.sv
`timescale 1ns/1ps
module i2c_reg_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [9:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic        reg_wr;
    logic        reg_rd;
    logic [31:0] reg_rdata;
    logic        scl_i;
    logic        sda_i;
    logic        perturb = 1'b0;
    logic        hit = 1'b0;

    int q = 25;
    int checks = 0;
    int errors = 0;
    int oe_viol = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign scl_i = scl_m;
    assign sda_i = sda_m & ~sda_oe;

    function automatic logic [31:0] model(input logic [9:0] a);
        return {a[9:2] ^ 8'h5A, 6'b0, a, a[7:0]};
    endfunction

    always @(posedge clk) begin
        if (!perturb) hit <= 1'b0;
        else if (reg_rd) hit <= 1'b1;
    end
    assign reg_rdata = hit ? 32'hBAD0_0BAD : model(reg_addr);

    i2c_reg_bridge u_i2c_reg_bridge (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_oe    (sda_oe),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- scoreboard ----------------
    typedef struct {
        bit          wr;
        logic [9:0]  addr;
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    task automatic push(input bit wr, input logic [9:0] a, input logic [31:0] d,
                        input string tag);
        exp_t e;
        e.wr = wr; e.addr = a; e.data = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    always @(negedge clk) begin
        exp_t e;
        if (rst_n && (reg_wr || reg_rd)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2", {21'b0, reg_wr, reg_addr}, 32'h0, "unexpected strobe");
            end else begin
                e = exp_q.pop_front();
                chk(reg_wr == e.wr, e.tag, {31'b0, reg_wr}, {31'b0, e.wr}, "strobe kind");
                chk(reg_addr == e.addr, e.tag, {22'b0, reg_addr}, {22'b0, e.addr}, "strobe address");
                if (e.wr) chk(reg_wdata == e.data, e.tag, reg_wdata, e.data, "write data");
            end
        end
    end

    // R11: drive changes only while SCL is low
    logic prev_oe = 1'b0;
    always @(negedge clk) begin
        if (rst_n && (sda_oe != prev_oe) && scl_i) oe_viol++;
        prev_oe = sda_oe;
    end

    // ---------------- bit-level controller ----------------
    task automatic wq();
        repeat (q) @(posedge clk);
        #1;
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
    endtask

    task automatic put_bit(input logic b, input bit glitch);
        sda_m = b; wq(); scl_m = 1'b1; wq();
        if (glitch) begin
            sda_m = 1'b0;
            repeat (2) @(posedge clk);
            #1;
            sda_m = 1'b1;
        end
        wq(); scl_m = 1'b0; wq();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_i; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, input bit glitch, output bit ack);
        logic nb;
        for (int i = 7; i >= 0; i--) put_bit(v[i], glitch && (i == 7));
        get_bit(nb);
        ack = ~nb;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] v);
        logic b;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            get_bit(b);
            v = {v[6:0], b};
        end
        put_bit(~mack, 1'b0);
    endtask

    task automatic send_ack(input logic [7:0] v, input bit exp_ack, input string tag,
                            input string what);
        bit ack;
        send_byte(v, 1'b0, ack);
        chk(ack == exp_ack, tag, {31'b0, ack}, {31'b0, exp_ack}, what);
    endtask

    task automatic wr_dword(input logic [31:0] d, input logic [9:0] a, input string tag,
                            input bit glitch);
        bit ack;
        push(1'b1, a, d, tag);
        for (int k = 3; k >= 0; k--) begin
            send_byte(d[8*k +: 8], glitch && (k == 3), ack);
            chk(ack, tag, {31'b0, ack}, 32'h1, "data byte ack");
        end
    endtask

    task automatic rd_dword(input logic [9:0] a, input bit nack_last, input string tag);
        logic [31:0] got;
        logic [7:0]  v;
        got = '0;
        for (int k = 0; k < 4; k++) begin
            recv_byte(!(nack_last && (k == 3)), v);
            got = {got[23:0], v};
        end
        chk(got == model(a), tag, got, model(a), "read word");
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 32'h0, 32'h1, "run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0] v;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        // R12 reset state
        chk(sda_oe == 1'b0, "R12", {31'b0, sda_oe}, 32'h0, "sda_oe after reset");
        chk(!reg_wr && !reg_rd, "R12", {30'b0, reg_wr, reg_rd}, 32'h0, "strobes after reset");
        chk(reg_addr == 10'h0, "R12", {22'b0, reg_addr}, 32'h0, "pointer after reset");

        // R1 R3 R4 R5: two-word write at index 0x05
        i2c_start();
        send_ack(8'h14, 1'b1, "R1", "control byte ack");
        send_ack(8'h05, 1'b1, "R3", "index byte ack");
        wr_dword(32'h1122_3344, 10'h014, "R4", 1'b0);
        wr_dword(32'hA5A5_5A5A, 10'h018, "R5", 1'b0);
        i2c_stop();

        // R6: partial word discarded, pointer kept at 0x080
        i2c_start();
        send_ack(8'h14, 1'b1, "R1", "control byte ack");
        send_ack(8'h20, 1'b1, "R3", "index byte ack");
        send_ack(8'hDE, 1'b1, "R6", "partial byte ack");
        send_ack(8'hAD, 1'b1, "R6", "partial byte ack");
        i2c_stop();
        i2c_start();
        push(1'b0, 10'h080, 32'h0, "R6");
        send_ack(8'h15, 1'b1, "R7", "read control ack");
        rd_dword(10'h080, 1'b1, "R6");
        i2c_stop();

        // R3 R5 R8 R9: index-only header, repeated start, wrap, NACK
        i2c_start();
        send_ack(8'h14, 1'b1, "R1", "control byte ack");
        send_ack(8'hFF, 1'b1, "R3", "index byte ack");
        push(1'b0, 10'h3FC, 32'h0, "R3");
        push(1'b0, 10'h000, 32'h0, "R5");
        i2c_start();
        send_ack(8'h15, 1'b1, "R7", "read control ack");
        rd_dword(10'h3FC, 1'b0, "R8");
        rd_dword(10'h000, 1'b1, "R8");
        recv_byte(1'b0, v);
        chk(v == 8'hFF, "R9", {24'b0, v}, 32'hFF, "bus released after NACK");
        i2c_stop();

        // R8: pointer advanced to 0x004; a one-byte read leaves it there
        i2c_start();
        push(1'b0, 10'h004, 32'h0, "R8");
        send_ack(8'h15, 1'b1, "R7", "read control ack");
        recv_byte(1'b0, v);
        chk(v == model(10'h004)[31:24], "R8", {24'b0, v}, {24'b0, model(10'h004)[31:24]}, "first byte");
        i2c_stop();
        i2c_start();
        push(1'b0, 10'h004, 32'h0, "R8");
        send_ack(8'h15, 1'b1, "R7", "read control ack");
        rd_dword(10'h004, 1'b1, "R8");
        i2c_stop();

        // R2: address mismatch, write then read direction
        i2c_start();
        send_ack(8'h16, 1'b0, "R2", "mismatch control nack");
        send_ack(8'h05, 1'b0, "R2", "ignored byte nack");
        send_ack(8'h12, 1'b0, "R2", "ignored byte nack");
        i2c_stop();
        i2c_start();
        send_ack(8'h95, 1'b0, "R2", "mismatch control nack");
        recv_byte(1'b0, v);
        chk(v == 8'hFF, "R2", {24'b0, v}, 32'hFF, "no data driven");
        i2c_stop();

        // R7: value latched at reg_rd; model changes right after
        perturb = 1'b1;
        i2c_start();
        send_ack(8'h14, 1'b1, "R1", "control byte ack");
        send_ack(8'h10, 1'b1, "R3", "index byte ack");
        push(1'b0, 10'h040, 32'h0, "R7");
        i2c_start();
        send_ack(8'h15, 1'b1, "R7", "read control ack");
        rd_dword(10'h040, 1'b1, "R7");
        i2c_stop();
        perturb = 1'b0;

        // R10: short SDA pulse while SCL high inside a data bit
        i2c_start();
        send_ack(8'h14, 1'b1, "R1", "control byte ack");
        send_ack(8'h30, 1'b1, "R3", "index byte ack");
        wr_dword(32'hFFFF_0001, 10'h0C0, "R10", 1'b1);
        i2c_stop();

        // R13: 400 kHz SCL
        q = 125;
        i2c_start();
        send_ack(8'h14, 1'b1, "R13", "control byte ack");
        send_ack(8'h7F, 1'b1, "R13", "index byte ack");
        wr_dword(32'hCAFE_F00D, 10'h1FC, "R13", 1'b0);
        push(1'b0, 10'h1FC, 32'h0, "R13");   // pointer was advanced to 0x200
        i2c_start();
        send_ack(8'h14, 1'b1, "R13", "control byte ack");
        send_ack(8'h7F, 1'b1, "R13", "index byte ack");
        i2c_start();
        send_ack(8'h15, 1'b1, "R13", "read control ack");
        rd_dword(10'h1FC, 1'b1, "R13");
        i2c_stop();
        q = 25;

        repeat (50) @(posedge clk);
        #1;
        chk(exp_q.size() == 0, "R4", exp_q.size(), 32'h0, "expected strobes left over");
        chk(oe_viol == 0, "R11", oe_viol, 32'h0, "SDA drive change with SCL high");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule